// File: doc/BRIEF.md
# Gated Store Buffer

This block sits between a core that executes speculatively and a memory write port. Stores from the core are held in a circular queue. The newest of them are speculative. A commit pulse marks every store held at that moment as final. A rollback pulse throws away every store that is still speculative. Only final stores leave the block. They go out one at a time, oldest first, over a valid/ready port.

Three pointers track the queue: a drain head, a gate and a fill tail. Entries from the head up to the gate are final. Entries from the gate up to the tail are speculative. A commit moves the gate to the tail, and a rollback pulls the tail back to the gate. Both take one cycle, whatever the number of entries involved. A combinational load port scans the live entries from oldest to youngest. For each byte lane it returns the data of the youngest matching store, speculative or not, so the core sees its own writes before memory does.

Top module: `gated_store_buffer`

## Requirements
- R1: After a synchronous active-high reset the buffer is empty: `st_stall` is 0, `mem_valid` is 0 and `ld_fwd_be` is 0 for every load address.
- R2: An accepted store is held as speculative and is never offered on the memory port until a later commit covers it.
- R3: A commit makes every store accepted in earlier cycles final. A store accepted in the same cycle as the commit stays speculative.
- R4: Final stores are offered in acceptance order, one per cycle, on `mem_valid`/`mem_ready`. While `mem_valid` is high and `mem_ready` is low, the address, data and byte enables hold steady.
- R5: A rollback discards every speculative store, and memory never receives any of them. A store presented in the same cycle is dropped. If commit and rollback arrive together, the rollback wins.
- R6: A rollback leaves final stores that are still waiting to drain untouched, and they still reach memory in order.
- R7: `st_stall` is 1 exactly when DEPTH stores (final plus speculative) are held. A store presented while `st_stall` is 1 is ignored.
- R8: `ld_fwd_be` bit b is 1 when some held store to word address `ld_addr` has byte enable b set. `ld_fwd_data` byte b then carries that byte from the youngest such store. Bytes that no held store supplies read as 0, and stores that have already drained are no longer forwarded.
- R9: Byte enable bit b covers data bits 8b+7..8b. The enables reach memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_stall | output | 1 | Buffer full; stores ignored |
| commit | input | 1 | Make all held speculative stores final |
| rollback | input | 1 | Discard all speculative stores |
| mem_valid | output | 1 | A final store is offered |
| mem_ready | input | 1 | Memory takes the offered store |
| mem_addr | output | ADDR_W | Offered store address |
| mem_data | output | DATA_W | Offered store data |
| mem_be | output | DATA_W/8 | Offered store byte enables |
| ld_addr | input | ADDR_W | Load word address to look up |
| ld_fwd_be | output | DATA_W/8 | Byte lanes supplied by the buffer |
| ld_fwd_data | output | DATA_W | Forwarded bytes, zero where not supplied |

## Verification
The assertions assume that reset is applied before any traffic and that commit and rollback are plain one-cycle pulses. They also assume that the memory side may hold `mem_ready` low for any length of time, so the checks on held payloads and surviving final entries must work under long backpressure. They do not assume the core honours `st_stall`. The stimulus therefore keeps presenting stores into a full buffer on purpose. It pulses commit and rollback at random rates, sometimes in the same cycle and sometimes together with a store. `mem_ready` toggles at random, and the addresses are drawn from eight words so that loads often hit several entries with overlapping byte enables.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } store_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } fwd_t;

    // Lay the enabled bytes of a store over an accumulated result.
    function automatic fwd_t overlay(fwd_t base, store_t s);
        fwd_t r;
        r = base;
        for (int b = 0; b < BE_W; b++) begin
            if (s.be[b]) begin
                r.data[8*b +: 8] = s.data[8*b +: 8];
                r.be[b]          = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/gsb_ctrl.sv
module gsb_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             st_valid,
    input  logic             commit,
    input  logic             rollback,
    input  logic             drain,
    output logic             accept,
    output logic             full,
    output logic             has_final,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [PTR_W-1:0] live
);
    logic [PTR_W-1:0] head_q, gate_q, tail_q;
    logic [PTR_W-1:0] final_cnt;

    assign live      = tail_q - head_q;
    assign final_cnt = gate_q - head_q;
    assign full      = (live == PTR_W'(DEPTH));
    assign has_final = (gate_q != head_q);
    assign accept    = st_valid && !full && !rollback;
    assign head_idx  = head_q[IDX_W-1:0];
    assign tail_idx  = tail_q[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            gate_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + PTR_W'(drain);
            if (rollback) begin
                tail_q <= gate_q;
            end else begin
                tail_q <= tail_q + PTR_W'(accept);
                if (commit) gate_q <= tail_q;
            end
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        live <= PTR_W'(DEPTH));
    assert_gate_inside_R3: assert property (@(posedge clk) disable iff (rst)
        final_cnt <= live);
    assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        full && !rollback |=> tail_q == $past(tail_q));
    assert_rollback_empties_R5: assert property (@(posedge clk) disable iff (rst)
        rollback |=> tail_q == gate_q);
endmodule

// File: rtl/gsb_fwd.sv
module gsb_fwd
    import gsb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  store_t            ent [DEPTH],
    input  logic [IDX_W-1:0]  head_idx,
    input  logic [PTR_W-1:0]  live,
    input  logic [ADDR_W-1:0] ld_addr,
    output fwd_t              result
);
    logic [IDX_W-1:0] idx;

    // Oldest to youngest: a younger hit overwrites the bytes it enables.
    always_comb begin
        result = '0;
        idx    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = head_idx + IDX_W'(i);
            if (PTR_W'(i) < live && ent[idx].addr == ld_addr)
                result = overlay(result, ent[idx]);
        end
    end
endmodule

// File: rtl/gated_store_buffer.sv
module gated_store_buffer
    import gsb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    output logic              st_stall,
    input  logic              commit,
    input  logic              rollback,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [BE_W-1:0]   mem_be,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [BE_W-1:0]   ld_fwd_be,
    output logic [DATA_W-1:0] ld_fwd_data
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    store_t           slots [DEPTH];
    logic             accept, full, has_final, drain;
    logic [IDX_W-1:0] head_idx, tail_idx;
    logic [PTR_W-1:0] live;
    store_t           out_ent;
    fwd_t             fwd;

    assign drain = mem_valid && mem_ready;

    gsb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .st_valid  (st_valid),
        .commit    (commit),
        .rollback  (rollback),
        .drain     (drain),
        .accept    (accept),
        .full      (full),
        .has_final (has_final),
        .head_idx  (head_idx),
        .tail_idx  (tail_idx),
        .live      (live)
    );

    always_ff @(posedge clk) begin
        if (accept) slots[tail_idx] <= '{addr: st_addr, data: st_data, be: st_be};
    end

    gsb_fwd #(.DEPTH(DEPTH)) u_fwd (
        .ent      (slots),
        .head_idx (head_idx),
        .live     (live),
        .ld_addr  (ld_addr),
        .result   (fwd)
    );

    assign out_ent     = slots[head_idx];
    assign st_stall    = full;
    assign mem_valid   = has_final;
    assign mem_addr    = out_ent.addr;
    assign mem_data    = out_ent.data;
    assign mem_be      = out_ent.be;
    assign ld_fwd_be   = fwd.be;
    assign ld_fwd_data = fwd.data;

    assert_hold_payload_R4: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_data) && $stable(mem_be));
    assert_rollback_keeps_final_R6: assert property (@(posedge clk) disable iff (rst)
        rollback && mem_valid && !mem_ready |=> mem_valid);
    assert_empty_after_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> !mem_valid && !st_stall);
endmodule

// File: tb/gated_store_buffer_test.sv
`timescale 1ns/1ps
module gated_store_buffer_test;
    localparam int DEPTH = 8;
    localparam int QN    = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 1'b0;
    logic [15:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = '0;
    logic        st_stall;
    logic        commit = 1'b0;
    logic        rollback = 1'b0;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0]  mem_be;
    logic [15:0] ld_addr = '0;
    logic [3:0]  ld_fwd_be;
    logic [31:0] ld_fwd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference queue: absolute positions, final below mg, speculative from mg to mt.
    int mh = 0, mg = 0, mt = 0;
    logic [15:0] qa [QN];
    logic [31:0] qd [QN];
    logic [3:0]  qb [QN];

    always #10 clk = ~clk;

    gated_store_buffer #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_stall(st_stall), .commit(commit), .rollback(rollback),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
        .ld_addr(ld_addr), .ld_fwd_be(ld_fwd_be), .ld_fwd_data(ld_fwd_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [35:0] model_fwd(input logic [15:0] a);
        logic [31:0] d = '0;
        logic [3:0]  b = '0;
        for (int k = mh; k < mt; k++) begin
            if (qa[k % QN] == a) begin
                for (int j = 0; j < 4; j++) begin
                    if (qb[k % QN][j]) begin
                        d[8*j +: 8] = qd[k % QN][8*j +: 8];
                        b[j] = 1'b1;
                    end
                end
            end
        end
        return {b, d};
    endfunction

    // One cycle: drive at the falling edge, check, then advance the model.
    task automatic step(input bit sv, input logic [15:0] a, input logic [31:0] d,
                        input logic [3:0] be, input bit cm, input bit rb,
                        input bit rdy, input logic [15:0] la);
        logic [35:0] f;
        bit full, acc, drn;
        int old_t;
        @(negedge clk);
        st_valid = sv; st_addr = a; st_data = d; st_be = be;
        commit = cm; rollback = rb; mem_ready = rdy; ld_addr = la;
        #1;
        full = ((mt - mh) == DEPTH);
        check("R7 stall when full", 64'(st_stall), 64'(full));
        check("R2 R3 R5 R6 only final stores offered", 64'(mem_valid), 64'(mh < mg));
        if (mh < mg) begin
            check("R4 drain order addr", 64'(mem_addr), 64'(qa[mh % QN]));
            check("R4 drain order data", 64'(mem_data), 64'(qd[mh % QN]));
            check("R9 byte enables to memory", 64'(mem_be), 64'(qb[mh % QN]));
        end
        f = model_fwd(la);
        check("R8 forward byte lanes", 64'(ld_fwd_be), 64'(f[35:32]));
        check("R8 forward data", 64'(ld_fwd_data), 64'(f[31:0]));
        drn = (mh < mg) && rdy;
        acc = sv && !full && !rb;
        old_t = mt;
        if (rb) begin
            mt = mg;
        end else begin
            if (acc) begin
                qa[mt % QN] = a; qd[mt % QN] = d; qb[mt % QN] = be;
                mt++;
            end
            if (cm) mg = old_t;
        end
        if (drn) mh++;
    endtask

    task automatic idle(input bit rdy);
        step(1'b0, 16'h0, 32'h0, 4'h0, 1'b0, 1'b0, rdy, 16'h1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: empty after reset
        check("R1 stall after reset", 64'(st_stall), 64'd0);
        check("R1 mem_valid after reset", 64'(mem_valid), 64'd0);
        ld_addr = 16'h1; #1;
        check("R1 no forwarding after reset", 64'(ld_fwd_be), 64'd0);
        rst = 1'b0;

        // R2 R8: speculative stores forwarded, not offered
        step(1, 16'h1, 32'h11223344, 4'b1111, 0, 0, 1, 16'h1);
        step(1, 16'h1, 32'hAABBCCDD, 4'b0101, 0, 0, 1, 16'h1);
        step(1, 16'h2, 32'h55667788, 4'b0010, 0, 0, 1, 16'h1);
        idle(1);
        // R3: store in the commit cycle stays speculative
        step(1, 16'h3, 32'hDEADBEEF, 4'b1001, 1, 0, 0, 16'h3);
        idle(0); idle(0);                 // R4: payload held under backpressure
        // R6: rollback with final stores pending
        step(0, 16'h0, 32'h0, 4'h0, 0, 1, 0, 16'h3);
        repeat (5) idle(1);
        // R7: fill past capacity while nothing drains
        for (int i = 0; i < DEPTH + 3; i++)
            step(1, 16'(i % 4), 32'(32'h01010101 * (i + 1)), 4'b1111, 0, 0, 0, 16'h2);
        step(0, 16'h0, 32'h0, 4'h0, 1, 0, 0, 16'h0);
        repeat (DEPTH + 2) idle(1);
        // R5: rollback wins over a commit in the same cycle, and drops the store
        step(1, 16'h4, 32'hCAFEF00D, 4'b1100, 0, 0, 1, 16'h4);
        step(1, 16'h4, 32'h12345678, 4'b0011, 1, 1, 1, 16'h4);
        repeat (3) idle(1);

        for (int n = 0; n < 3000; n++) begin
            step(($urandom % 10) < 6, 16'($urandom % 8), $urandom, 4'($urandom),
                 ($urandom % 10) == 0, ($urandom % 20) == 0,
                 ($urandom % 2) == 0, 16'($urandom % 8));
        end
        step(0, 16'h0, 32'h0, 4'h0, 1, 0, 1, 16'h0);
        repeat (DEPTH + 2) idle(1);
        check("R4 everything drained", 64'(mem_valid), 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule